// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the control and status register set of one descriptor-driven DMA channel. Software reaches it through a simple 32-bit register port and uses it to enable the channel, to choose how work is started, to pause the channel and to soft-reset it. The block reports a 4-bit channel state and a quiescent flag. A driver uses them to bring the channel down in a fixed order: request pause, wait for the paused state, wait for quiescence, trigger soft reset, wait for the idle state, and finally clear enable.

The block drives two qualifiers to the queue engine. One allows descriptor fetch. The other is a clear pulse that returns the engine's queue head, tail and completion phase to their reset values. From the engine it takes a descriptor-in-flight flag, an outstanding bus transaction count, and completion and error events. Those events are latched into a write-1-to-clear interrupt status register, and each status bit can be enabled onto the interrupt output.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset the control register reads 0x8000_0000 once the outstanding count has been zero for a cycle. The interrupt status and interrupt enable registers read 0, and `irq`, `eng_run` and `eng_qclr` are low.
- R2: The control register at offset 0x000 has three writable bits: bit 0 enables the channel, bit 1 requests pause and bit 9 selects the work mode. A write stores all three bits. Writes to read-only bits (31, 19:16) have no effect.
- R3: Control bits 19:16 report the state: 0 idle, 1 running, 2 draining, 3 paused, 4 resetting. With pause clear, setting enable moves the channel from idle to running. `eng_run` is high only while running.
- R4: Setting pause while running moves the channel to draining. It stays there while `eng_busy` is high and moves to paused only after `eng_busy` is low. `eng_run` is low in both states.
- R5: Control bit 31 reads 1 when `eng_outst` was zero on the previous cycle and 0 otherwise.
- R6: Writing control bit 3 as 1 enters the resetting state from any state. `eng_qclr` is then high for exactly RST_CYC cycles and bit 3 reads 1. After that the state returns to 0 and the pause bit is cleared. The channel stays idle until enable has been written 0 and then 1.
- R7: An `eng_cmp` pulse sets status bit 16 of the interrupt status register at offset 0x00C. An `eng_err` pulse sets bit 17 and ORs `eng_cause` into bits 27:20. The bits hold until cleared.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clearing write wins, so the bit stays set.
- R9: The interrupt enable register at offset 0x010 stores bits 16, 17 and 27:20, and its other bits read 0. `irq` is high when any status bit and its matching enable bit are both 1.
- R10: A read of any other offset returns 0. A write to any other offset changes no register.
- R11: `eng_dbmode` is high when control bit 9 is 0, which is the doorbell-driven mode.
- R12: Clearing pause while paused with enable set returns the channel to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Register access strobe |
| csr_we | input | 1 | 1 write, 0 read |
| csr_addr | input | ADDR_W | Byte offset of the register |
| csr_wdata | input | 32 | Write data |
| csr_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| csr_rdata | output | 32 | Read data |
| eng_busy | input | 1 | A descriptor is in flight in the engine |
| eng_outst | input | OUTST_W | Outstanding bus transaction count |
| eng_cmp | input | 1 | Completion event pulse |
| eng_err | input | 1 | Error event pulse |
| eng_cause | input | 8 | Error cause bits, valid with `eng_err` |
| eng_run | output | 1 | The engine may fetch and start descriptors |
| eng_qclr | output | 1 | Clears the engine's queue pointers and phase bit |
| eng_dbmode | output | 1 | Doorbell-driven work mode selected |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the state field never leaves its five encodings;
- `eng_run` only follows a cycle with enable set and pause clear;
- the paused state is entered only after a cycle with no descriptor in flight;
- the clear pulse ends in idle and never exceeds RST_CYC cycles;
- completion events always latch, and a clearing write without a coincident event always clears.

Only the bench's scenarios can show the rest:
- read-modify-write preservation of fields and the mask on read-only bits;
- the value of the quiescent flag through the drain;
- the exact reset duration and the rule that enable must be rewritten before the channel runs again;
- cause accumulation, event-beats-clear, interrupt gating and unmapped offsets.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned OFF_CTL   = 'h000;
  localparam int unsigned OFF_ISTAT = 'h00C;
  localparam int unsigned OFF_IMASK = 'h010;

  // control register bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_PAUSE = 1;
  localparam int unsigned CB_SRST  = 3;
  localparam int unsigned CB_MODE  = 9;
  localparam int unsigned CB_ST_LO = 16;
  localparam int unsigned CB_QUIET = 31;

  // interrupt register bit positions
  localparam int unsigned IB_CMP   = 16;
  localparam int unsigned IB_ERR   = 17;
  localparam int unsigned IB_CAUSE = 20;
  localparam int unsigned CAUSE_W  = 8;
  localparam logic [31:0] IRQ_BITS = 32'h0FF3_0000;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_RUN    = 4'd1,
    ST_DRAIN  = 4'd2,
    ST_PAUSED = 4'd3,
    ST_RESET  = 4'd4
  } chan_st_e;

endpackage

// File: rtl/chan_ctl_reg.sv
module chan_ctl_reg
  import dma_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctl,
  input  logic [31:0] wdata,
  input  logic        clr_pause,
  output logic        ctl_en,
  output logic        ctl_pause,
  output logic        ctl_mode
);

  logic en_n, pause_n, mode_n;

  always_comb begin
    en_n    = ctl_en;
    pause_n = ctl_pause;
    mode_n  = ctl_mode;
    if (wr_ctl) begin
      en_n    = wdata[CB_EN];
      pause_n = wdata[CB_PAUSE];
      mode_n  = wdata[CB_MODE];
    end
    if (clr_pause) pause_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en    <= 1'b0;
      ctl_pause <= 1'b0;
      ctl_mode  <= 1'b0;
    end else begin
      ctl_en    <= en_n;
      ctl_pause <= pause_n;
      ctl_mode  <= mode_n;
    end
  end

endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import dma_csr_pkg::*;
#(
  parameter int unsigned OUTST_W = 6,
  parameter int unsigned RST_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_en,
  input  logic               ctl_pause,
  input  logic               srst_trig,
  input  logic               eng_busy,
  input  logic [OUTST_W-1:0] eng_outst,
  output chan_st_e           st,
  output logic               quiet,
  output logic               rst_done,
  output logic               run,
  output logic               qclr
);

  localparam int unsigned CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC - 1);

  chan_st_e         st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             hold_q, hold_n;
  logic             quiet_n;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt_q;
    rst_done = 1'b0;
    if (srst_trig && st != ST_RESET) begin
      st_n  = ST_RESET;
      cnt_n = CNT_LOAD;
    end else begin
      unique case (st)
        ST_IDLE:   if (ctl_en && !ctl_pause && !hold_q) st_n = ST_RUN;
        ST_RUN:    if (!ctl_en) st_n = ST_IDLE;
                   else if (ctl_pause) st_n = ST_DRAIN;
        ST_DRAIN:  if (!eng_busy) st_n = ST_PAUSED;
        ST_PAUSED: if (!ctl_pause) st_n = ctl_en ? ST_RUN : ST_IDLE;
        ST_RESET: begin
          if (cnt_q == '0) begin
            st_n     = ST_IDLE;
            rst_done = 1'b1;
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
        default:   st_n = ST_IDLE;
      endcase
    end
    hold_n = hold_q;
    if (rst_done)     hold_n = 1'b1;
    else if (!ctl_en) hold_n = 1'b0;
    quiet_n = (eng_outst == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      quiet  <= 1'b0;
    end else begin
      st     <= st_n;
      cnt_q  <= cnt_n;
      hold_q <= hold_n;
      quiet  <= quiet_n;
    end
  end

  assign run  = (st == ST_RUN);
  assign qclr = (st == ST_RESET);

endmodule

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
  import dma_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stat,
  input  logic               wr_mask,
  input  logic [31:0]        wdata,
  input  logic               ev_cmp,
  input  logic               ev_err,
  input  logic [CAUSE_W-1:0] ev_cause,
  output logic [31:0]        stat_q,
  output logic [31:0]        mask_q,
  output logic               irq
);

  logic [31:0] stat_n, mask_n, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[IB_CMP] = ev_cmp;
    set_vec[IB_ERR] = ev_err;
    if (ev_err) set_vec[IB_CAUSE +: CAUSE_W] = ev_cause;
    clr_vec = wr_stat ? (wdata & IRQ_BITS) : '0;
    stat_n  = (stat_q & ~clr_vec) | set_vec;
    mask_n  = wr_mask ? (wdata & IRQ_BITS) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
    end
  end

  assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned OUTST_W = 6,
  parameter int unsigned RST_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_req,
  input  logic               csr_we,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic [31:0]        csr_wdata,
  output logic               csr_rvalid,
  output logic [31:0]        csr_rdata,
  input  logic               eng_busy,
  input  logic [OUTST_W-1:0] eng_outst,
  input  logic               eng_cmp,
  input  logic               eng_err,
  input  logic [7:0]         eng_cause,
  output logic               eng_run,
  output logic               eng_qclr,
  output logic               eng_dbmode,
  output logic               irq
);

  logic sel_ctl, sel_stat, sel_mask;
  logic wr_ctl, wr_stat, wr_mask, rd_en;
  logic ctl_en, ctl_pause, ctl_mode;
  logic quiet, rst_done, srst_trig;
  chan_st_e st;
  logic [31:0] stat_q, mask_q, ctl_view, rd_mux;

  assign sel_ctl  = (csr_addr == ADDR_W'(OFF_CTL));
  assign sel_stat = (csr_addr == ADDR_W'(OFF_ISTAT));
  assign sel_mask = (csr_addr == ADDR_W'(OFF_IMASK));
  assign wr_ctl   = csr_req && csr_we && sel_ctl;
  assign wr_stat  = csr_req && csr_we && sel_stat;
  assign wr_mask  = csr_req && csr_we && sel_mask;
  assign rd_en    = csr_req && !csr_we;
  assign srst_trig = wr_ctl && csr_wdata[CB_SRST];

  chan_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (wr_ctl),
    .wdata     (csr_wdata),
    .clr_pause (rst_done),
    .ctl_en    (ctl_en),
    .ctl_pause (ctl_pause),
    .ctl_mode  (ctl_mode)
  );

  chan_seq #(.OUTST_W(OUTST_W), .RST_CYC(RST_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_en    (ctl_en),
    .ctl_pause (ctl_pause),
    .srst_trig (srst_trig),
    .eng_busy  (eng_busy),
    .eng_outst (eng_outst),
    .st        (st),
    .quiet     (quiet),
    .rst_done  (rst_done),
    .run       (eng_run),
    .qclr      (eng_qclr)
  );

  chan_irq_regs u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask),
    .wdata    (csr_wdata),
    .ev_cmp   (eng_cmp),
    .ev_err   (eng_err),
    .ev_cause (eng_cause),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  always_comb begin
    ctl_view = '0;
    ctl_view[CB_EN]    = ctl_en;
    ctl_view[CB_PAUSE] = ctl_pause;
    ctl_view[CB_SRST]  = (st == ST_RESET);
    ctl_view[CB_MODE]  = ctl_mode;
    ctl_view[CB_ST_LO +: 4] = st;
    ctl_view[CB_QUIET] = quiet;
    rd_mux = '0;
    if (sel_ctl)  rd_mux = ctl_view;
    if (sel_stat) rd_mux = stat_q;
    if (sel_mask) rd_mux = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_rvalid <= 1'b0;
      csr_rdata  <= '0;
    end else begin
      csr_rvalid <= rd_en;
      if (rd_en) csr_rdata <= rd_mux;
    end
  end

  assign eng_dbmode = !ctl_mode;

endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned RST_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        st,
  input logic              ctl_en,
  input logic              ctl_pause,
  input logic              eng_run,
  input logic              eng_qclr,
  input logic              eng_busy,
  input logic              eng_cmp,
  input logic [31:0]       stat_q,
  input logic              csr_req,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [31:0]       csr_wdata
);

  localparam int unsigned RW = $clog2(RST_CYC + 2) + 1;
  logic [RW-1:0] qclr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        qclr_run <= '0;
    else if (eng_qclr) qclr_run <= qclr_run + 1'b1;
    else               qclr_run <= '0;
  end

  p_state_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st <= 4'd4);

  p_run_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run |-> ($past(ctl_en) && !$past(ctl_pause)));

  p_pause_after_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == 4'd3) |-> !$past(eng_busy));

  p_reset_ends_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_qclr) |-> st == 4'd0);

  p_reset_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qclr_run <= RW'(RST_CYC));

  p_cmp_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmp |=> stat_q[IB_CMP]);

  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && csr_addr == ADDR_W'(OFF_ISTAT) && csr_wdata[IB_CMP] && !eng_cmp)
      |=> !stat_q[IB_CMP]);

endmodule

bind dma_chan_csr dma_chan_csr_chk #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (st),
  .ctl_en    (ctl_en),
  .ctl_pause (ctl_pause),
  .eng_run   (eng_run),
  .eng_qclr  (eng_qclr),
  .eng_busy  (eng_busy),
  .eng_cmp   (eng_cmp),
  .stat_q    (stat_q),
  .csr_req   (csr_req),
  .csr_we    (csr_we),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata)
);

// File: tb/sim_dma_chan_csr.sv
`timescale 1ns/1ps
module sim_dma_chan_csr;

  localparam int ADDR_W = 12;
  localparam int OUTST_W = 6;
  localparam int RST_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_req = 1'b0, csr_we = 1'b0;
  logic [ADDR_W-1:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic csr_rvalid;
  logic [31:0] csr_rdata;
  logic eng_busy = 1'b0;
  logic [OUTST_W-1:0] eng_outst = '0;
  logic eng_cmp = 1'b0, eng_err = 1'b0;
  logic [7:0] eng_cause = '0;
  logic eng_run, eng_qclr, eng_dbmode, irq;

  int n_cmp = 0, n_bad = 0, qclr_cnt = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  dma_chan_csr #(.ADDR_W(ADDR_W), .OUTST_W(OUTST_W), .RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rvalid(csr_rvalid),
    .csr_rdata(csr_rdata), .eng_busy(eng_busy), .eng_outst(eng_outst),
    .eng_cmp(eng_cmp), .eng_err(eng_err), .eng_cause(eng_cause),
    .eng_run(eng_run), .eng_qclr(eng_qclr), .eng_dbmode(eng_dbmode), .irq(irq)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (eng_qclr) qclr_cnt++;
    if (rst_n && csr_rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data %h", csr_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (csr_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: read %h expected %h", t, csr_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    csr_req = 1'b1; csr_we = 1'b1; csr_addr = ADDR_W'(a); csr_wdata = d;
    @(negedge clk);
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    csr_req = 1'b1; csr_we = 1'b0; csr_addr = ADDR_W'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    csr_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(irq, 1'b0, "R1 irq");
    chk(eng_run, 1'b0, "R1 run");
    chk(eng_qclr, 1'b0, "R1 qclr");
    rst_n = 1'b1;
    idle(2);
    rd('h000, 32'h8000_0000, "R1 ctl");
    rd('h00C, 32'h0, "R1 istat");
    rd('h010, 32'h0, "R1 imask");

    // R2 / R11: field storage and read-only bits
    wr('h000, 32'h0000_0200);
    rd('h000, 32'h8000_0200, "R2 mode store");
    chk(eng_dbmode, 1'b0, "R11 mode1");
    wr('h000, 32'hFFF0_FDF4);
    rd('h000, 32'h8000_0000, "R2 ro bits");
    chk(eng_dbmode, 1'b1, "R11 mode0");

    // R3 enable
    wr('h000, 32'h1);
    idle(2);
    rd('h000, 32'h8001_0001, "R3 running");
    chk(eng_run, 1'b1, "R3 run");

    // R5 quiescent
    eng_outst = 6'd3;
    idle(2);
    rd('h000, 32'h0001_0001, "R5 not quiet");

    // R4 drain then pause
    eng_busy = 1'b1;
    wr('h000, 32'h3);
    idle(3);
    rd('h000, 32'h0002_0003, "R4 draining");
    chk(eng_run, 1'b0, "R4 run low");
    eng_busy = 1'b0;
    idle(3);
    rd('h000, 32'h0003_0003, "R4 paused");
    eng_outst = 6'd0;
    idle(2);
    rd('h000, 32'h8003_0003, "R5 quiet");

    // R12 resume
    wr('h000, 32'h1);
    idle(3);
    rd('h000, 32'h8001_0001, "R12 resume");
    wr('h000, 32'h3);
    idle(3);
    rd('h000, 32'h8003_0003, "R4 paused again");

    // R6 soft reset
    qclr_cnt = 0;
    wr('h000, 32'hB);
    rd('h000, 32'h8004_000B, "R6 resetting");
    idle(8);
    n_cmp++;
    if (qclr_cnt != RST_CYC) begin
      n_bad++;
      $display("FAIL R6 qclr cycles %0d expected %0d", qclr_cnt, RST_CYC);
    end
    rd('h000, 32'h8000_0001, "R6 idle after reset");
    idle(3);
    rd('h000, 32'h8000_0001, "R6 held idle");
    chk(eng_run, 1'b0, "R6 no run");
    wr('h000, 32'h0);
    wr('h000, 32'h1);
    idle(2);
    rd('h000, 32'h8001_0001, "R6 rerun");

    // R9 mask register
    wr('h010, 32'hFFFF_FFFF);
    rd('h010, 32'h0FF3_0000, "R9 mask bits");
    wr('h010, 32'h0001_0000);

    // R7 events
    eng_cmp = 1'b1; idle(1); eng_cmp = 1'b0;
    rd('h00C, 32'h0001_0000, "R7 cmp");
    chk(irq, 1'b1, "R9 irq cmp");
    eng_err = 1'b1; eng_cause = 8'h5A; idle(1); eng_err = 1'b0; eng_cause = 8'h0;
    rd('h00C, 32'h05A3_0000, "R7 err");

    // R8 clear rules
    wr('h00C, 32'h0);
    rd('h00C, 32'h05A3_0000, "R8 write zero");
    wr('h00C, 32'h0001_0000);
    rd('h00C, 32'h05A2_0000, "R8 clear cmp");
    chk(irq, 1'b0, "R9 irq gated");
    wr('h00C, 32'h0FF2_0000);
    rd('h00C, 32'h0, "R8 clear all");
    eng_err = 1'b1; eng_cause = 8'h01; idle(1);
    eng_cause = 8'h80; idle(1); eng_err = 1'b0; eng_cause = 8'h0;
    rd('h00C, 32'h0812_0000, "R7 cause or");
    eng_cmp = 1'b1;
    wr('h00C, 32'h0001_0000);
    eng_cmp = 1'b0;
    rd('h00C, 32'h0813_0000, "R8 event wins");

    // R10 unmapped
    rd('h004, 32'h0, "R10 read");
    wr('h004, 32'hFFFF_FFFF);
    wr('h014, 32'hFFFF_FFFF);
    rd('h000, 32'h8001_0001, "R10 ctl unchanged");
    rd('h010, 32'h0001_0000, "R10 mask unchanged");
    rd('hFFC, 32'h0, "R10 read high");

    idle(4);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL missing read data count %0d", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule